// File: doc/BRIEF.md
# Increment-Decrement Counter Oscillator

This block is the oscillator stage of an all-digital phase locked loop. It runs from one fixed fast clock and walks a four-state toggle machine. In each cycle the machine is either high or low. The pulse output carries one single-cycle pulse for every cycle the machine spends low. With no corrections pending, the machine alternates high and low, so the pulse rate is half the clock rate.

The loop filter sends carry pulses (speed up) and borrow pulses (slow down). Each one is caught on its rising edge and held as a pending correction. A carry is applied only from the high state. It inserts one extra low interval, which adds one output pulse and advances the output by one clock period. A borrow is applied only from the low state. It inserts one extra high interval, which removes one output pulse and delays the output by one clock period. Under a steady stream of corrections, the rate is therefore held between one third and two thirds of the clock rate.

A counter divides the pulse stream by an even ratio. It produces a square-wave feedback signal for the phase detector.

The toggle machine has four states:
- TG_HIGH is the normal high state. It goes to TG_LOW_X and consumes a carry when a carry is pending. Otherwise it goes to TG_LOW.
- TG_LOW is the normal low state. It goes to TG_HIGH_X and consumes a borrow when a borrow is pending. Otherwise it goes to TG_HIGH.
- TG_LOW_X is the inserted low state. It always goes to TG_LOW.
- TG_HIGH_X is the inserted high state. It always goes to TG_HIGH.

Reset enters TG_HIGH.

Top module: `incdec_dco`

## Requirements
- R1: While rst_n is low, id_out and fb_out are 0, and the toggle machine is held in TG_HIGH.
- R2: With no carry or borrow events, id_out alternates every cycle: 0 in the first sampled cycle after reset, then 1, 0, 1 and so on. Any 30-cycle window therefore holds 15 pulses.
- R3: A single carry event adds exactly one pulse to the stream (two consecutive low intervals). After it, the stream equals the uncorrected stream delayed by one cycle.
- R4: With a carry event always pending, the pattern is high-low-low. That gives 20 pulses in 30 cycles, never more than two pulses in a row, and no two idle cycles in a row.
- R5: A single borrow event removes exactly one pulse (two consecutive high intervals). After it, the stream equals the uncorrected stream delayed by one cycle.
- R6: With a borrow event always pending, the pattern is low-high-high. That gives 10 pulses in 30 cycles, never two pulses in a row, and at most two idle cycles in a row.
- R7: carry_in and borrow_in act on rising edges only. A level held high for many cycles causes exactly one correction, the same as a one-cycle pulse.
- R8: A carry edge and a borrow edge in the same cycle cancel each other. The output is identical to the uncorrected stream.
- R9: fb_out changes level the cycle after every DIV_N/2-th pulse on id_out. It is a square wave with a period of DIV_N pulses (DIV_N = 4 by default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed oscillator clock; all logic is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| carry_in | input | 1 | Speed-up request from the loop filter, rising-edge sensitive |
| borrow_in | input | 1 | Slow-down request from the loop filter, rising-edge sensitive |
| id_out | output | 1 | Registered one-cycle pulse for each low interval of the toggle machine |
| fb_out | output | 1 | Square wave at the pulse rate divided by DIV_N |

## Verification
A rising edge on carry_in or borrow_in is captured into a pending flag at the first clock edge. The machine can consume that flag one or two edges later, depending on whether it is in the state that accepts that correction. The inserted interval appears on id_out one edge after that. Because this latency depends on phase, the single-event checks do not sample a fixed cycle. Each one records a 64-cycle trace from a fixed point after reset and compares it with an uncorrected trace of the same length. The comparison covers the pulse count, corrected by the last reference sample, and a one-cycle shift over the later half of the trace. Rate checks wait 12 cycles for the pending flags to saturate before counting over a 30-cycle window. The fb_out check relies on the level changing exactly one edge after the pulse that completes a group.

// File: rtl/incdec_dco_pkg.sv
package incdec_dco_pkg;

    // Toggle machine states: two normal, two inserted by corrections.
    typedef enum logic [1:0] {
        TG_HIGH   = 2'd0,
        TG_LOW    = 2'd1,
        TG_LOW_X  = 2'd2,
        TG_HIGH_X = 2'd3
    } tog_state_e;

    // Index of each correction source in the event vectors.
    localparam int EV_CARRY  = 0;
    localparam int EV_BORROW = 1;
    localparam int EV_COUNT  = 2;

    function automatic logic tog_is_low(input tog_state_e s);
        return (s == TG_LOW) || (s == TG_LOW_X);
    endfunction

endpackage

// File: rtl/incdec_event_catch.sv
module incdec_event_catch
    import incdec_dco_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EV_COUNT-1:0] ev_in,
    input  logic [EV_COUNT-1:0] take,
    output logic [EV_COUNT-1:0] pend
);

    logic [EV_COUNT-1:0] ev_q;
    logic [EV_COUNT-1:0] ev_edge;
    logic [EV_COUNT-1:0] pend_n;

    // One edge detector per correction source.
    for (genvar gi = 0; gi < EV_COUNT; gi++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ev_q[gi] <= 1'b0;
            else        ev_q[gi] <= ev_in[gi];
        end
        assign ev_edge[gi] = ev_in[gi] & ~ev_q[gi];
    end

    always_comb begin
        logic new_c;
        logic new_b;
        new_c  = ev_edge[EV_CARRY]  & ~ev_edge[EV_BORROW];
        new_b  = ev_edge[EV_BORROW] & ~ev_edge[EV_CARRY];
        pend_n = pend & ~take;
        // A new event of one kind annihilates an unapplied event of the other.
        if (new_c) begin
            if (pend_n[EV_BORROW]) pend_n[EV_BORROW] = 1'b0;
            else                   pend_n[EV_CARRY]  = 1'b1;
        end
        if (new_b) begin
            if (pend_n[EV_CARRY]) pend_n[EV_CARRY]  = 1'b0;
            else                  pend_n[EV_BORROW] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_n;
    end

    // R8
    cancel_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_edge[EV_CARRY] && ev_edge[EV_BORROW] && pend == '0) |=> (pend == '0));

    // R7
    carry_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[EV_CARRY]) |-> $past(ev_edge[EV_CARRY]));

    // R7
    borrow_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[EV_BORROW]) |-> $past(ev_edge[EV_BORROW]));

endmodule

// File: rtl/incdec_toggle_fsm.sv
module incdec_toggle_fsm
    import incdec_dco_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EV_COUNT-1:0] pend,
    output logic [EV_COUNT-1:0] take,
    output logic                id_out
);

    tog_state_e state;
    tog_state_e state_n;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TG_HIGH;
        else        state <= state_n;
    end

    // Next state and consumption of pending corrections.
    always_comb begin
        state_n = state;
        take    = '0;
        unique case (state)
            TG_HIGH: begin
                if (pend[EV_CARRY]) begin
                    state_n        = TG_LOW_X;
                    take[EV_CARRY] = 1'b1;
                end else begin
                    state_n = TG_LOW;
                end
            end
            TG_LOW: begin
                if (pend[EV_BORROW]) begin
                    state_n         = TG_HIGH_X;
                    take[EV_BORROW] = 1'b1;
                end else begin
                    state_n = TG_HIGH;
                end
            end
            TG_LOW_X:  state_n = TG_LOW;
            TG_HIGH_X: state_n = TG_HIGH;
            default:   state_n = TG_HIGH;
        endcase
    end

    // Output register: one pulse per low interval.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) id_out <= 1'b0;
        else        id_out <= tog_is_low(state);
    end

    // R3
    carry_two_lows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take[EV_CARRY] |-> ##2 id_out ##1 id_out);

    // R5
    borrow_two_highs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take[EV_BORROW] |-> ##2 !id_out ##1 !id_out);

endmodule

// File: rtl/incdec_fb_divider.sv
module incdec_fb_divider #(
    parameter int DIV_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic id_pulse,
    output logic fb_out
);

    localparam int HALF = DIV_N / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            fb_out <= 1'b0;
        end else if (id_pulse) begin
            if (cnt == LAST) begin
                cnt    <= '0;
                fb_out <= ~fb_out;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R9
    fb_moves_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fb_out) |-> $past(id_pulse));

endmodule

// File: rtl/incdec_dco.sv
module incdec_dco
    import incdec_dco_pkg::*;
#(
    parameter int DIV_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carry_in,
    input  logic borrow_in,
    output logic id_out,
    output logic fb_out
);

    logic [EV_COUNT-1:0] ev_in;
    logic [EV_COUNT-1:0] pend;
    logic [EV_COUNT-1:0] take;

    assign ev_in[EV_CARRY]  = carry_in;
    assign ev_in[EV_BORROW] = borrow_in;

    incdec_event_catch u_catch (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_in (ev_in),
        .take  (take),
        .pend  (pend)
    );

    incdec_toggle_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .take   (take),
        .id_out (id_out)
    );

    if (DIV_N >= 2) begin : g_div
        incdec_fb_divider #(.DIV_N(DIV_N)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .id_pulse (id_out),
            .fb_out   (fb_out)
        );
    end else begin : g_nodiv
        assign fb_out = id_out;
    end

    // R4
    max_two_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_out && $past(id_out)) |=> !id_out);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!id_out && !fb_out));

endmodule

// File: tb/sim_incdec_dco.sv
module sim_incdec_dco;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_N      = 4;
    localparam int HALF       = DIV_N / 2;
    localparam int WIN        = 30;
    localparam int SETTLE     = 12;
    localparam int TRLEN      = 64;

    // Columns: mode (bit0 carry train, bit1 borrow train), pulses, max run of 1, max run of 0
    localparam int TBL [4][4] = '{
        '{0, 15, 1, 1},
        '{1, 20, 2, 1},
        '{2, 10, 1, 2},
        '{3, 15, 1, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carry_in = 1'b0;
    logic borrow_in = 1'b0;
    logic id_out;
    logic fb_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    incdec_dco #(.DIV_N(DIV_N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .carry_in  (carry_in),
        .borrow_in (borrow_in),
        .id_out    (id_out),
        .fb_out    (fb_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        carry_in = 1'b0;
        borrow_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Runs one table row: settle with the stimulus trains, then measure a window.
    task automatic run_row(input int mode, output int pulses, output int run1,
                           output int run0, output int fb_bad);
        int r1;
        int r0;
        int grp;
        bit seen;
        logic fb_prev;
        pulses = 0; run1 = 0; run0 = 0; fb_bad = 0;
        r1 = 0; r0 = 0; grp = 0; seen = 1'b0;
        do_reset();
        fb_prev = 1'b0;
        for (int k = 0; k < SETTLE + WIN; k++) begin
            @(negedge clk);
            if (k >= SETTLE) begin
                if (fb_out != fb_prev) begin
                    if (seen && grp != HALF) fb_bad++;
                    seen = 1'b1;
                    grp = 0;
                end
                if (id_out) begin
                    pulses++; grp++; r1++; r0 = 0;
                end else begin
                    r0++; r1 = 0;
                end
                if (r1 > run1) run1 = r1;
                if (r0 > run0) run0 = r0;
            end
            fb_prev = fb_out;
            carry_in  = mode[0] && (k % 2 == 0);
            borrow_in = mode[1] && (k % 2 == 0);
        end
        carry_in = 1'b0;
        borrow_in = 1'b0;
    endtask

    // kind: 0 none, 1 carry pulse, 2 borrow pulse, 3 both pulses, 4 carry held high
    task automatic trace_run(input int kind, output logic [TRLEN-1:0] tr);
        do_reset();
        for (int k = 0; k < TRLEN; k++) begin
            @(negedge clk);
            tr[k] = id_out;
            carry_in  = ((kind == 1 || kind == 3) && k == 10) || (kind == 4 && k >= 10 && k < 40);
            borrow_in = (kind == 2 || kind == 3) && k == 10;
        end
        carry_in = 1'b0;
        borrow_in = 1'b0;
    endtask

    function automatic int ones(input logic [TRLEN-1:0] v);
        int n = 0;
        for (int i = 0; i < TRLEN; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int shift_bad(input logic [TRLEN-1:0] a, input logic [TRLEN-1:0] ref_tr);
        int n = 0;
        for (int i = 32; i < TRLEN; i++) if (a[i] != ref_tr[i-1]) n++;
        return n;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [TRLEN-1:0] t_ref;
        logic [TRLEN-1:0] t_car;
        logic [TRLEN-1:0] t_bor;
        logic [TRLEN-1:0] t_both;
        logic [TRLEN-1:0] t_hold;
        int p, a1, a0, fb_bad, alt_bad;

        // R1: outputs quiet during reset
        repeat (2) @(negedge clk);
        check("R1 id_out in reset", int'(id_out), 0);
        check("R1 fb_out in reset", int'(fb_out), 0);

        // Table walk: R2 nominal, R4 carry train, R6 borrow train, R8 both trains
        for (int r = 0; r < 4; r++) begin
            run_row(TBL[r][0], p, a1, a0, fb_bad);
            check($sformatf("R2/R4/R6/R8 row%0d pulses", r), p, TBL[r][1]);
            check($sformatf("R4/R6 row%0d max pulse run", r), a1, TBL[r][2]);
            check($sformatf("R4/R6 row%0d max idle run", r), a0, TBL[r][3]);
            check($sformatf("R9 row%0d fb group size", r), fb_bad, 0);
        end

        // Directed single-event traces
        trace_run(0, t_ref);
        trace_run(1, t_car);
        trace_run(2, t_bor);
        trace_run(3, t_both);
        trace_run(4, t_hold);

        alt_bad = 0;
        for (int i = 1; i < TRLEN; i++) if (t_ref[i] == t_ref[i-1]) alt_bad++;
        check("R2 alternation", alt_bad, 0);
        check("R2 first sample", int'(t_ref[0]), 0);

        check("R3 carry adds one pulse", ones(t_car), ones(t_ref) + 1 - int'(t_ref[TRLEN-1]));
        check("R3 carry shifts stream", shift_bad(t_car, t_ref), 0);
        check("R5 borrow removes one pulse", ones(t_bor), ones(t_ref) - int'(t_ref[TRLEN-1]));
        check("R5 borrow shifts stream", shift_bad(t_bor, t_ref), 0);
        check("R8 same-cycle cancel", int'(t_both != t_ref), 0);
        check("R7 held level equals one pulse", int'(t_hold != t_car), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule